// File: doc/BRIEF.md
# Dimming Period Timebase Selector

This block decides which timebase marks the start of each dimming-PWM period for a bank of lamp-inverter channels. It produces a one-cycle `period_stb` pulse that downstream duty-cycle counters use to restart their periods. Strobes come either from an internal free-running divider or from the rising edges of an external synchronisation input, so that dimming can be locked to a video frame rate.

A two-bit mode input selects one of four behaviours: internal only, automatic, external only, or a fourth code that acts as internal only. A bypass input overrides the mode and forces the internal divider. The external input is brought into the clock domain by a two-flop synchroniser. Its rising edges are watched against a programmable gap limit to decide whether a sync source is present. In automatic mode the block follows the external edges while they keep coming and falls back to the divider when they stop. In external-only mode a silent input simply produces no strobes. The status output `ext_active` tells which source currently drives the strobe.

With the default parameters at a 50 MHz clock, the divider gives about 160 Hz. A gap limit of 833333 cycles is the recommended timeout, one 60 Hz frame.

Top module: `dim_timebase_sel`

## Requirements
- R1: While `rst` is high, `period_stb` and `ext_active` are 0. After reset, no sync source is considered present, so in automatic mode (code 01, the intended reset value of the mode field) the first strobes come from the internal divider.
- R2: With mode 00 or 11 and bypass 0, `period_stb` pulses exactly every INT_DIV clock cycles, `ext_active` is 0, and activity on `sync_in` has no effect on the strobe timing.
- R3: With `bypass` = 1, the block behaves as in R2 whatever the mode code, including 01 and 10 with sync edges arriving.
- R4: With mode 10 and bypass 0, each rising edge of `sync_in` gives exactly one strobe. The strobe is high during the cycle after the third rising clock edge that follows the change of `sync_in`.
- R5: With mode 10 and bypass 0, `ext_active` is 1, and no strobe is produced while `sync_in` has no rising edges.
- R6: A sync source becomes present when two consecutive synchronised rising edges are at most `timeout_lim` cycles apart. In automatic mode, `ext_active` then goes to 1 and strobes follow the external edges only.
- R7: A present source becomes absent when no rising edge has arrived for `timeout_lim`+2 cycles. In automatic mode, `ext_active` then returns to 0.
- R8: When automatic mode falls back from external to internal, the divider starts again from zero. The first internal strobe is high exactly INT_DIV cycles after `ext_active` falls.
- R9: Rising edges spaced more than `timeout_lim` cycles apart never make a source present. In automatic mode, strobes then keep the internal INT_DIV spacing.
- R10: `period_stb` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Source mode: 00 internal, 01 automatic, 10 external, 11 internal |
| bypass | input | 1 | 1 forces the internal divider |
| timeout_lim | input | GAP_W | Maximum edge spacing, in cycles, for a present sync source |
| sync_in | input | 1 | External sync input, asynchronous |
| period_stb | output | 1 | One-cycle dimming period start strobe |
| ext_active | output | 1 | 1 when the external input is the selected source |

## Verification
The assertions assume that `mode`, `bypass` and `timeout_lim` change only between tests and stay stable while spacing is being measured. They also assume that every high or low phase of `sync_in` lasts at least two clock cycles, so the synchroniser sees each edge. The bench drives all inputs on falling clock edges. It builds the sync waveform from pulse trains with a whole number of cycles per period, split into halves of several cycles each. It waits longer than the gap limit between scenarios, so that each test starts with no source present.

// File: rtl/dimsrc_pkg.sv
package dimsrc_pkg;

    typedef enum logic [1:0] {
        SRC_INT     = 2'b00,
        SRC_AUTO    = 2'b01,
        SRC_EXT     = 2'b10,
        SRC_INT_ALT = 2'b11
    } src_mode_e;

    typedef struct packed {
        logic stb;
        logic ext_sel;
    } tb_sel_t;

    function automatic logic mode_wants_ext(src_mode_e m, logic present, logic byp);
        return !byp && ((m == SRC_EXT) || ((m == SRC_AUTO) && present));
    endfunction

endpackage

// File: rtl/dimsrc_sync_edge.sv
module dimsrc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    assert_rise_single_R10: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/dimsrc_presence.sv
module dimsrc_presence #(
    parameter int GAP_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic [GAP_W-1:0] lim,
    output logic             present
);
    logic [GAP_W-1:0] gap;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= '0;
            seen    <= 1'b0;
            present <= 1'b0;
        end else if (rise) begin
            present <= seen && (gap < lim);
            seen    <= 1'b1;
            gap     <= '0;
        end else begin
            if (gap >= lim) begin
                present <= 1'b0;
                seen    <= 1'b0;
            end
            if (gap != '1) gap <= gap + 1'b1;
        end
    end

    assert_absent_after_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (!rise && gap >= lim) |=> !present);
    assert_present_on_close_edges_R6: assert property (@(posedge clk) disable iff (rst)
        (rise && seen && gap < lim) |=> present);
    assert_wide_gap_not_present_R9: assert property (@(posedge clk) disable iff (rst)
        (rise && gap >= lim) |=> !present);
endmodule

// File: rtl/dimsrc_divider.sv
module dimsrc_divider #(
    parameter int DIV = 312500
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic stb
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign stb = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (stb)   cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    assert_div_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/dim_timebase_sel.sv
module dim_timebase_sel
    import dimsrc_pkg::*;
#(
    parameter int INT_DIV     = 312500,
    parameter int GAP_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             bypass,
    input  logic [GAP_W-1:0] timeout_lim,
    input  logic             sync_in,
    output logic             period_stb,
    output logic             ext_active
);
    src_mode_e mode_v;
    logic      rise;
    logic      present;
    logic      div_stb;
    tb_sel_t   sel;

    assign mode_v = src_mode_e'(mode);

    dimsrc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (sync_in),
        .rise(rise)
    );

    dimsrc_presence #(.GAP_W(GAP_W)) u_pres (
        .clk    (clk),
        .rst    (rst),
        .rise   (rise),
        .lim    (timeout_lim),
        .present(present)
    );

    always_comb begin
        sel.ext_sel = mode_wants_ext(mode_v, present, bypass);
        sel.stb     = sel.ext_sel ? rise : div_stb;
    end

    dimsrc_divider #(.DIV(INT_DIV)) u_div (
        .clk(clk),
        .rst(rst),
        .clr(sel.ext_sel),
        .stb(div_stb)
    );

    always_ff @(posedge clk) begin
        if (rst) period_stb <= 1'b0;
        else     period_stb <= sel.stb;
    end

    assign ext_active = rst ? 1'b0 : sel.ext_sel;

    assert_stb_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        period_stb |=> !period_stb);
    assert_internal_ignores_sync_R2: assert property (@(posedge clk) disable iff (rst)
        (!ext_active && !div_stb) |=> !period_stb);
    assert_external_edges_only_R4: assert property (@(posedge clk) disable iff (rst)
        (ext_active && !rise) |=> !period_stb);
    assert_bypass_internal_R3: assert property (@(posedge clk) disable iff (rst)
        bypass |-> !ext_active);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !period_stb);
endmodule

// File: tb/tb_dim_timebase_sel.sv
`timescale 1ns/1ps
module tb_dim_timebase_sel;
    localparam int DIV = 20;
    localparam int GW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b01;
    logic          bypass = 1'b0;
    logic [GW-1:0] lim = 8'd50;
    logic          sync_in = 1'b0;
    logic          period_stb;
    logic          ext_active;

    int checks = 0;
    int errors = 0;
    int m_cnt, m_min, m_max, m_wide;
    bit done = 0;

    always #10 clk = ~clk;

    dim_timebase_sel #(.INT_DIV(DIV), .GAP_W(GW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .mode(mode), .bypass(bypass),
        .timeout_lim(lim), .sync_in(sync_in),
        .period_stb(period_stb), .ext_active(ext_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic train(input int n, input int p);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sync_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            sync_in = 1'b0;
            repeat (p - p / 2 - 1) @(negedge clk);
        end
    endtask

    task automatic measure(input int n);
        int  last = -1;
        logic prev = 1'b0;
        m_cnt = 0; m_min = 1 << 30; m_max = 0; m_wide = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (period_stb) begin
                if (prev) m_wide++;
                else begin
                    m_cnt++;
                    if (last >= 0) begin
                        if (i - last < m_min) m_min = i - last;
                        if (i - last > m_max) m_max = i - last;
                    end
                    last = i;
                end
            end
            prev = period_stb;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        // R1: reset state
        repeat (5) begin
            @(negedge clk);
            chk(period_stb == 0 && ext_active == 0, "R1 reset outputs", {period_stb, ext_active}, 0);
        end
        rst = 1'b0;
        measure(110);
        chk(m_min == DIV && m_max == DIV && m_cnt >= 4, "R1 internal after reset", m_min, DIV);
        chk(ext_active == 0, "R1 status after reset", ext_active, 0);

        // R2: internal modes ignore sync
        for (int m = 0; m < 4; m += 3) begin
            mode = 2'(m);
            idle(30);
            fork train(15, 14); measure(220); join
            chk(m_min == DIV && m_max == DIV, "R2 internal spacing", m_max, DIV);
            chk(m_cnt >= 10, "R2 strobe count", m_cnt, 11);
            chk(ext_active == 0, "R2 status", ext_active, 0);
        end

        // R3: bypass forces internal
        bypass = 1'b1;
        for (int m = 1; m < 3; m++) begin
            mode = 2'(m);
            idle(30);
            fork train(8, 30); measure(250); join
            chk(m_min == DIV && m_max == DIV, "R3 bypass spacing", m_max, DIV);
            chk(ext_active == 0, "R3 bypass status", ext_active, 0);
        end
        bypass = 1'b0;

        // R4: external only, latency and one strobe per edge
        mode = 2'b10;
        idle(60);
        sync_in = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk(period_stb == 0, "R4 no early strobe", period_stb, 0);
        @(posedge clk); #1;
        chk(period_stb == 1, "R4 strobe latency", period_stb, 1);
        @(posedge clk); #1;
        chk(period_stb == 0, "R10 width one", period_stb, 0);
        @(negedge clk) sync_in = 1'b0;
        idle(10);
        fork train(8, 30); measure(260); join
        chk(m_cnt == 8, "R4 strobe per edge", m_cnt, 8);
        chk(m_min == 30 && m_max == 30, "R4 spacing follows sync", m_max, 30);
        chk(m_wide == 0, "R10 single-cycle strobes", m_wide, 0);

        // R5: external only, silent input
        measure(200);
        chk(m_cnt == 0, "R5 no strobes without sync", m_cnt, 0);
        chk(ext_active == 1, "R5 status external", ext_active, 1);

        // R6: automatic lock
        mode = 2'b01;
        idle(80);
        chk(ext_active == 0, "R6 not present yet", ext_active, 0);
        train(3, 30);
        chk(ext_active == 1, "R6 present after close edges", ext_active, 1);
        fork train(6, 30); measure(190); join
        chk(m_cnt == 6 && m_min == 30 && m_max == 30, "R6 strobes follow sync", m_cnt, 6);

        // R7, R8: loss of sync and fallback
        idle(10);
        chk(ext_active == 1, "R7 still present inside window", ext_active, 1);
        t = 0;
        while (ext_active && t < 60) begin @(negedge clk); t++; end
        chk(ext_active == 0 && t <= 40, "R7 absent after timeout", t, 40);
        t = 0;
        while (!period_stb && t < 100) begin @(negedge clk); t++; end
        chk(t == DIV, "R8 first internal strobe after fallback", t, DIV);

        // R9: wide spacing never locks
        idle(60);
        fork train(8, 60); measure(480); join
        chk(ext_active == 0, "R9 wide spacing not present", ext_active, 0);
        chk(m_min == DIV && m_max == DIV, "R9 internal spacing kept", m_max, DIV);

        // R6/R9 sweep over the gap limit
        for (int l = 25; l <= 40; l += 15) begin
            lim = 8'(l);
            idle(l + 10);
            train(3, l);
            chk(ext_active == 1, "R6 spacing equal to limit", ext_active, 1);
            idle(l + 10);
            chk(ext_active == 0, "R7 absent in sweep", ext_active, 0);
            train(3, l + 3);
            chk(ext_active == 0, "R9 spacing above limit", ext_active, 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule